// File: doc/BRIEF.md
# UART hardware flow control

This block sits beside the receive FIFO and the transmit shifter of a FIFO-based UART. It produces the active-low request-to-send pin and a one-cycle start pulse that tells the transmit shifter it may begin the next character. Software can drive the request pin directly from a modem control bit. With automatic flow control enabled, the block also withdraws the request whenever the receive FIFO has filled to a programmable threshold. In the same mode it holds back new transmit characters until the far end signals clear-to-send.

Two UARTs wired this way, each with its request pin connected to the other's clear-to-send input, cannot overrun each other's receive FIFO. A sender only starts a character while the receiver reports space. Character framing, the baud generator, the FIFOs and the register decode lie outside this block. They reach it as plain levels and counts.

Top module: `uart_flowctl`

## Requirements
- R1: While `rst_n` is low, `rts_n_o` is 1 (inactive) on every clock after the first edge. With `auto_flow_en_i` high during reset, `tx_start_o` is 0 whatever `cts_n_i` is.
- R2: With `auto_flow_en_i` and `loop_mode_i` both low, `rts_n_o` equals the inverse of `mcr_rts_i` as sampled at the previous clock edge.
- R3: With `loop_mode_i` high at a clock edge, `rts_n_o` is 1 after that edge, whatever the other inputs are.
- R4: With `auto_flow_en_i` and `mcr_rts_i` high and loop mode off, `rts_n_o` becomes 0 after an edge where `rx_level_i` is below the threshold. It becomes 1 after an edge where `rx_level_i` is at or above the threshold. When the level falls back below the threshold, the request returns on the next clock.
- R5: Automatic mode never forces the request on. With `mcr_rts_i` low, `rts_n_o` is 1 after the edge, even when the receive FIFO is empty.
- R6: `rx_trig_sel_i` selects the threshold, for a 64-entry FIFO: 2'b00 gives 1 entry, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 56.
- R7: `cts_n_i` passes through a two-flop synchronizer. The gate uses the pin value sampled two clock edges earlier. After reset the synchronizer reads inactive (1).
- R8: With `auto_flow_en_i` low, `tx_start_o` equals `tx_data_avail_i & ~tx_busy_i`, independent of `cts_n_i`.
- R9: With `auto_flow_en_i` high, `tx_start_o` is 1 only if `tx_data_avail_i` is 1, `tx_busy_i` is 0 and the synchronized `cts_n_i` is 0 (active).
- R10: `tx_start_o` is 0 while `tx_busy_i` is 1. A character already being shifted out is not cut short by a drop of clear-to-send. The gate consults clear-to-send only at the next character boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mcr_rts_i | input | 1 | Modem control request bit (1 = request) |
| auto_flow_en_i | input | 1 | Enables automatic request and clear-to-send gating |
| loop_mode_i | input | 1 | Loopback mode flag; forces the request pin inactive |
| rx_level_i | input | LVL_W (7) | Receive FIFO fill level, 0 to FIFO_DEPTH |
| rx_trig_sel_i | input | 2 | Receive threshold select |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_data_avail_i | input | 1 | Transmit FIFO holds a character |
| tx_busy_i | input | 1 | Transmit shifter is sending a character |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| tx_start_o | output | 1 | Permission pulse for the shifter to begin a character |

## Verification
The request pin is exercised in several ways:
- Direct toggling of the control bit in manual mode, which separates a registered output from a combinational one and confirms the polarity.
- A loopback window, which shows whether loop mode overrides an asserted control bit.
- A sweep of every fill level from 0 to 64 under each of the four threshold codes. This exposes off-by-one errors at the threshold and any swapped encodings.

Clear-to-send is exercised in two ways:
- It toggles while automatic mode is off, and then again while it is on. This shows whether the gate depends on the enable at all, and whether the two-edge synchronizer delay is exactly two.
- It drops during a busy character, which confirms that the gate waits for the character boundary.

A pseudo-random phase mixes all inputs to catch interactions between the request path and the gate.

// File: rtl/uart_fc_pkg.sv
// Shared definitions for the UART flow-control block.
// Assumes the receive FIFO depth is a multiple of 8 so the derived thresholds are exact.
package uart_fc_pkg;

    // Receive threshold codes as seen on the select input.
    typedef enum logic [1:0] {
        TRIG_ONE       = 2'b00,
        TRIG_QUARTER   = 2'b01,
        TRIG_HALF      = 2'b10,
        TRIG_NEAR_FULL = 2'b11
    } trig_sel_e;

    // Map a threshold code to a number of FIFO entries for the given depth.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (trig_sel_e'(sel))
            TRIG_ONE:       return 1;
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            default:        return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_fc_cts_sync.sv
// Multi-stage synchronizer for the asynchronous clear-to-send pin.
// Assumes STAGES >= 2. Every stage resets to RESET_VAL, so the pin reads inactive after reset.
module uart_fc_cts_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Later stages: shift the sample one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/uart_fc_rts_ctrl.sv
// Request-to-send generator.
// The pin follows the modem control bit. Loop mode and reset force it inactive.
// In automatic mode the pin is also withdrawn once the receive fill level reaches the selected threshold.
// Assumes rx_level_i never exceeds FIFO_DEPTH. The output is registered and reacts one clock after its inputs.
module uart_fc_rts_ctrl
    import uart_fc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_rts_i,
    input  logic             auto_en_i,
    input  logic             loop_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [1:0]       trig_sel_i,
    output logic             rts_n_o
);

    logic [LVL_W-1:0] thresh;
    logic             room_left;
    logic             request;
    logic             rts_n_q;

    // Decode the selected threshold and compare the fill level against it.
    always_comb begin
        thresh    = LVL_W'(trig_level(trig_sel_i, FIFO_DEPTH));
        room_left = (rx_level_i < thresh);
    end

    // Automatic mode can only remove the request, never add one.
    always_comb begin
        request = mcr_rts_i && !loop_i && (!auto_en_i || room_left);
    end

    // Register the pin so it changes one clock after its inputs; reset leaves it inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n_q <= 1'b1;
        else        rts_n_q <= !request;
    end

    assign rts_n_o = rts_n_q;

endmodule

// File: rtl/uart_fc_tx_gate.sv
// Transmit start gate.
// Grants a start only when the shifter is idle (a character boundary) and data is waiting.
// In automatic mode clear-to-send must also be active.
// Assumes the shifter raises its busy flag in the clock after it accepts a start.
module uart_fc_tx_gate (
    input  logic auto_en_i,
    input  logic cts_ok_i,
    input  logic data_avail_i,
    input  logic busy_i,
    output logic start_o
);

    logic boundary;
    logic clear;

    // A new character may begin only while nothing is on the line.
    always_comb begin
        boundary = !busy_i;
        clear    = !auto_en_i || cts_ok_i;
        start_o  = data_avail_i && boundary && clear;
    end

endmodule

// File: rtl/uart_flowctl.sv
// UART hardware flow control top level.
// Connects the clear-to-send synchronizer, the request-to-send generator and the transmit start gate.
// Assumes every input except cts_n_i is synchronous to clk. The reset is synchronous and active low.
module uart_flowctl
    import uart_fc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH  = 64,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_rts_i,
    input  logic             auto_flow_en_i,
    input  logic             loop_mode_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [1:0]       rx_trig_sel_i,
    input  logic             cts_n_i,
    input  logic             tx_data_avail_i,
    input  logic             tx_busy_i,
    output logic             rts_n_o,
    output logic             tx_start_o
);

    logic cts_n_sync;
    logic cts_active;

    // Bring the asynchronous pin into the clock domain; it reads inactive after reset.
    uart_fc_cts_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_n_i),
        .sync_o  (cts_n_sync)
    );

    // Convert the active-low synchronized pin to a positive enable.
    always_comb begin
        cts_active = !cts_n_sync;
    end

    uart_fc_rts_ctrl #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W)
    ) u_rts_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mcr_rts_i  (mcr_rts_i),
        .auto_en_i  (auto_flow_en_i),
        .loop_i     (loop_mode_i),
        .rx_level_i (rx_level_i),
        .trig_sel_i (rx_trig_sel_i),
        .rts_n_o    (rts_n_o)
    );

    uart_fc_tx_gate u_tx_gate (
        .auto_en_i    (auto_flow_en_i),
        .cts_ok_i     (cts_active),
        .data_avail_i (tx_data_avail_i),
        .busy_i       (tx_busy_i),
        .start_o      (tx_start_o)
    );

endmodule

// File: rtl/uart_flowctl_chk.sv
// Property checker for uart_flowctl. It observes the top-level ports only.
// Assumes the same parameter values as the module it is bound to.
module uart_flowctl_chk
    import uart_fc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mcr_rts_i,
    input logic             auto_flow_en_i,
    input logic             loop_mode_i,
    input logic [LVL_W-1:0] rx_level_i,
    input logic [1:0]       rx_trig_sel_i,
    input logic             cts_n_i,
    input logic             tx_data_avail_i,
    input logic             tx_busy_i,
    input logic             rts_n_o,
    input logic             tx_start_o
);

    logic [LVL_W-1:0] chk_thresh;

    // Threshold as the checker understands it.
    always_comb begin
        chk_thresh = LVL_W'(trig_level(rx_trig_sel_i, FIFO_DEPTH));
    end

    // R1: reset leaves the request pin inactive.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> rts_n_o);

    // R2: manual mode mirrors the control bit one clock later.
    a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_flow_en_i && !loop_mode_i) |=> (rts_n_o == !$past(mcr_rts_i)));

    // R3: loop mode forces the pin inactive.
    a_r3_loop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode_i |=> rts_n_o);

    // R4: reaching the threshold in automatic mode withdraws the request.
    a_r4_full_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_flow_en_i && rx_level_i >= chk_thresh) |=> rts_n_o);

    // R5: automatic mode never raises a request the control bit does not ask for.
    a_r5_auto_no_force: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rts_i |=> rts_n_o);

    // R8: without automatic mode the gate ignores clear-to-send.
    a_r8_manual_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_flow_en_i && tx_data_avail_i && !tx_busy_i) |-> tx_start_o);

    // R9: an automatic-mode start needs clear-to-send sampled two edges earlier.
    a_r9_cts_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_flow_en_i && tx_start_o) |-> !$past(cts_n_i, 2));

    // R10: no start while a character is on the line.
    a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |-> !tx_start_o);

endmodule

bind uart_flowctl uart_flowctl_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
) u_chk (.*);

// File: tb/uart_flowctl_bench.sv
// Bench for uart_flowctl.
// A behavioural reference model advances on every clock edge and is compared with the outputs at each falling edge.
module uart_flowctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcr_rts = 1'b0;
    logic       auto_en = 1'b0;
    logic       loop_m = 1'b0;
    logic [6:0] rx_level = '0;
    logic [1:0] trig_sel = 2'b00;
    logic       cts_n = 1'b1;
    logic       tx_avail = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rts_n;
    logic       tx_start;

    int    checks = 0;
    int    failures = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int m_rts_n = 1;
    int cts_pipe[$];

    always #10 clk = ~clk;

    uart_flowctl u_uart_flowctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .mcr_rts_i       (mcr_rts),
        .auto_flow_en_i  (auto_en),
        .loop_mode_i     (loop_m),
        .rx_level_i      (rx_level),
        .rx_trig_sel_i   (trig_sel),
        .cts_n_i         (cts_n),
        .tx_data_avail_i (tx_avail),
        .tx_busy_i       (tx_busy),
        .rts_n_o         (rts_n),
        .tx_start_o      (tx_start)
    );

    // Threshold table for a 64-entry FIFO (R6).
    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 56;
        endcase
    endfunction

    // Model: advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rts_n = 1;
            cts_pipe = '{1, 1};
        end else begin
            int want;
            want = (mcr_rts && !loop_m && (!auto_en || int'(rx_level) < thr_of(trig_sel))) ? 1 : 0;
            m_rts_n = want ? 0 : 1;
            cts_pipe.push_back(int'(cts_n));
            void'(cts_pipe.pop_front());
        end
    end

    // Compare the outputs with the model at each falling edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            int exp_start;
            exp_start = (tx_avail && !tx_busy && (!auto_en || cts_pipe[0] == 0)) ? 1 : 0;
            checks++;
            if (int'(rts_n) != m_rts_n) begin
                failures++;
                $display("FAIL %s rts_n_o actual=%0d expected=%0d t=%0t", cur_req, rts_n, m_rts_n, $time);
            end
            checks++;
            if (int'(tx_start) != exp_start) begin
                failures++;
                $display("FAIL %s tx_start_o actual=%0d expected=%0d t=%0t", cur_req, tx_start, exp_start, $time);
            end
        end
    end

    // Advance one clock; inputs change shortly after the rising edge.
    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #3;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;

        // R1: reset state, with automatic mode on and data waiting.
        cur_req  = "R1";
        auto_en  = 1'b1;
        tx_avail = 1'b1;
        mcr_rts  = 1'b1;
        cts_n    = 1'b0;
        tick();
        chk_en = 1'b1;
        tick(3);
        rst_n    = 1'b1;
        auto_en  = 1'b0;
        tx_avail = 1'b0;
        cts_n    = 1'b1;

        // R2: manual mode follows the control bit.
        cur_req = "R2";
        foreach (lfsr[i]) begin
            mcr_rts = lfsr[i];
            tick();
        end
        mcr_rts = 1'b1;
        tick(2);

        // R3: loop mode overrides an asserted control bit.
        cur_req = "R3";
        loop_m = 1'b1;
        tick(3);
        auto_en = 1'b1;
        tick(2);
        loop_m  = 1'b0;
        auto_en = 1'b0;
        tick(2);

        // R6: sweep every level under each threshold code.
        cur_req = "R6";
        auto_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int lvl = 0; lvl <= 64; lvl++) begin
                rx_level = 7'(lvl);
                tick();
            end
        end

        // R4: fill to the threshold, then a read drops the level by one.
        cur_req  = "R4";
        trig_sel = 2'b11;
        rx_level = 7'd56;
        tick(2);
        rx_level = 7'd55;
        tick(2);
        trig_sel = 2'b00;
        rx_level = 7'd0;
        tick();
        rx_level = 7'd1;
        tick(2);

        // R5: control bit clear, empty FIFO, automatic mode on.
        cur_req  = "R5";
        mcr_rts  = 1'b0;
        rx_level = 7'd0;
        tick(3);
        mcr_rts = 1'b1;
        tick();

        // R8: clear-to-send ignored outside automatic mode.
        cur_req  = "R8";
        auto_en  = 1'b0;
        tx_avail = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cts_n = k[0];
            tick();
        end
        cts_n = 1'b1;
        tick(3);

        // R7: two-edge synchronizer delay, seen through the gate.
        cur_req = "R7";
        auto_en = 1'b1;
        cts_n   = 1'b0;
        tick(4);
        cts_n = 1'b1;
        tick(4);
        cts_n = 1'b0;
        tick();
        cts_n = 1'b1;
        tick(3);

        // R9: automatic gate with data present and absent.
        cur_req = "R9";
        cts_n   = 1'b0;
        tick(3);
        tx_avail = 1'b0;
        tick(2);
        tx_avail = 1'b1;
        tick(2);

        // R10: clear-to-send drops mid-character; no start until the boundary.
        cur_req = "R10";
        tx_busy = 1'b1;
        tick();
        cts_n = 1'b1;
        tick(4);
        tx_busy = 1'b0;
        tick(2);
        cts_n = 1'b0;
        tick(3);

        // Mixed random stimulus across both paths (R4 and R9 interaction).
        cur_req = "R4_R9_mix";
        for (int k = 0; k < 400; k++) begin
            lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mcr_rts  = lfsr[0] | lfsr[1];
            auto_en  = lfsr[2] | lfsr[3];
            loop_m   = (lfsr[4:2] == 3'b000);
            trig_sel = lfsr[6:5];
            rx_level = 7'(lfsr[12:7] + lfsr[13]);
            cts_n    = lfsr[14];
            tx_avail = lfsr[15] | lfsr[8];
            tx_busy  = lfsr[9] & lfsr[11];
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule